// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This combinational block takes one packed binary floating-point operand in half, single or double precision and splits it into a form that arithmetic datapaths can consume. It reports what kind of value the operand holds (zero, finite, infinity, quiet NaN or signalling NaN). For finite values it drives the sign, an unbiased two's-complement exponent and a 64-bit mantissa whose leading one always sits at bit 62, whatever the source format.

Subnormal operands are normalized on the way through, so downstream logic never sees a mantissa with its leading one below bit 62. Two flush controls can turn subnormals into zeros: one for single and double, one for half. An alternative-half control makes the top half-precision exponent an ordinary range instead of the infinity/NaN encoding. The block only raises an input-denormal flag when a single or double subnormal is flushed. It takes no action of its own on that flag.

Top module: `fpu_operand_unpack`

## Requirements
- R1: An operand whose exponent and fraction fields are both zero gives kind 0 (zero). sign_o equals the operand sign, exp_o and mant_o are 0, and in_denorm_o is 0.
- R2: A single or double subnormal (exponent field zero, fraction nonzero) with flush_i=1 gives kind 0 with the operand sign, exp_o=0, mant_o=0 and in_denorm_o=1.
- R3: A half subnormal with flush_half_i=1 gives kind 0 with in_denorm_o=0. flush_i has no effect on half operands, and flush_half_i has no effect on single or double operands.
- R4: A subnormal that is not flushed gives kind 1 (finite). mant_o is the fraction shifted left so that its highest set bit h lands at bit 62. exp_o = (1 - bias) - F + h, where F is the fraction width (10/23/52) and the bias is 15/127/1023.
- R5: An all-ones exponent with a zero fraction gives kind 2 (infinity) with the operand sign, exp_o=0 and mant_o=0 (for half only when alt_half_i=0).
- R6: An all-ones exponent with a nonzero fraction gives kind 3 (quiet NaN) when the fraction MSB is 1 and kind 4 (signalling NaN) when it is 0. exp_o and mant_o are 0 (for half only when alt_half_i=0).
- R7: With alt_half_i=1, a half operand whose exponent field is 31 is a finite normal with exp_o=16. alt_half_i has no effect on single or double operands.
- R8: A normal operand gives kind 1, exp_o = exponent field - bias, and mant_o = (2^F + fraction) << (62 - F).
- R9: fmt_i selects the format: 0 selects half in operand_i[15:0], 1 selects single in operand_i[31:0], and both 2 and 3 select double in operand_i[63:0]. Operand bits above the selected width have no effect.
- R10: in_denorm_o is 1 only in the R2 case and 0 for every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 64 | Packed operand, right-aligned for half and single |
| fmt_i | input | 2 | Format select: 0 half, 1 single, 2 or 3 double |
| flush_i | input | 1 | Flush subnormals to zero for single and double |
| flush_half_i | input | 1 | Flush subnormals to zero for half |
| alt_half_i | input | 1 | Treat the top half exponent as a normal range |
| kind_o | output | 3 | 0 zero, 1 finite, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| sign_o | output | 1 | Operand sign |
| exp_o | output | 12 | Unbiased signed exponent (finite only, else 0) |
| mant_o | output | 64 | Mantissa with leading one at bit 62 (finite only, else 0) |
| in_denorm_o | output | 1 | A single or double subnormal was flushed |

## Verification
The assertions sit on combinational paths, so they assume that every input is a known 0 or 1 whenever they are evaluated. They also assume that only the four format codes exist; code 3 is simply mapped onto double. The stimulus satisfies this because the bench holds every input at a defined value from time zero, including during reset, and changes inputs only on falling clock edges. The sweeps push random-looking bits into the operand's unused upper lanes and into the controls that do not apply to the selected format. This exercises the ignore rules, and none of these values leaves the legal input space.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

  localparam int MANT_W   = 64;
  localparam int POINT    = 62;
  localparam int EXP_W    = 12;
  localparam int FRAC_MAX = 52;
  localparam int EXPF_MAX = 11;
  localparam int POS_W    = $clog2(FRAC_MAX);
  localparam int PAD_W    = MANT_W - FRAC_MAX;
  localparam int TAIL_W   = MANT_W - 2 - FRAC_MAX;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_WIDE   = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    K_ZERO   = 3'd0,
    K_FINITE = 3'd1,
    K_INF    = 3'd2,
    K_QNAN   = 3'd3,
    K_SNAN   = 3'd4
  } kind_e;

  typedef struct packed {
    logic                sign;
    logic [EXPF_MAX-1:0] exp_raw;
    logic [FRAC_MAX-1:0] frac_left;
    logic                exp_zero;
    logic                exp_ones;
  } fields_t;

  function automatic logic signed [EXP_W-1:0] fmt_bias(fmt_e f);
    case (f)
      FMT_HALF:   return 12'sd15;
      FMT_SINGLE: return 12'sd127;
      default:    return 12'sd1023;
    endcase
  endfunction

  // Smallest normal exponent of a format.
  function automatic logic signed [EXP_W-1:0] fmt_emin(fmt_e f);
    return 12'sd1 - fmt_bias(f);
  endfunction

endpackage

// File: rtl/fpu_unpack_fields.sv
module fpu_unpack_fields
  import fpu_unpack_pkg::*;
(
  input  logic [63:0] op_i,
  input  fmt_e        fmt_i,
  output fields_t     fld_o
);

  always_comb begin
    case (fmt_i)
      FMT_HALF: begin
        fld_o.sign      = op_i[15];
        fld_o.exp_raw   = {6'b0, op_i[14:10]};
        fld_o.frac_left = {op_i[9:0], 42'b0};
        fld_o.exp_ones  = &op_i[14:10];
      end
      FMT_SINGLE: begin
        fld_o.sign      = op_i[31];
        fld_o.exp_raw   = {3'b0, op_i[30:23]};
        fld_o.frac_left = {op_i[22:0], 29'b0};
        fld_o.exp_ones  = &op_i[30:23];
      end
      default: begin
        fld_o.sign      = op_i[63];
        fld_o.exp_raw   = op_i[62:52];
        fld_o.frac_left = op_i[51:0];
        fld_o.exp_ones  = &op_i[62:52];
      end
    endcase
    fld_o.exp_zero = (fld_o.exp_raw == '0);
  end

endmodule

// File: rtl/fpu_unpack_classify.sv
module fpu_unpack_classify
  import fpu_unpack_pkg::*;
(
  input  fields_t fld_i,
  input  fmt_e    fmt_i,
  input  logic    flush_i,
  input  logic    flush_half_i,
  input  logic    alt_half_i,
  output kind_e   kind_o,
  output logic    subnormal_o,
  output logic    denorm_flag_o
);

  logic is_half;
  logic frac_zero;
  logic flush_sel;
  logic special_exp;

  assign is_half     = (fmt_i == FMT_HALF);
  assign frac_zero   = (fld_i.frac_left == '0);
  assign flush_sel   = is_half ? flush_half_i : flush_i;
  assign special_exp = fld_i.exp_ones && !(is_half && alt_half_i);

  always_comb begin
    kind_o        = K_FINITE;
    subnormal_o   = 1'b0;
    denorm_flag_o = 1'b0;
    if (fld_i.exp_zero) begin
      if (frac_zero) begin
        kind_o = K_ZERO;
      end else if (flush_sel) begin
        kind_o        = K_ZERO;
        denorm_flag_o = !is_half;
      end else begin
        subnormal_o = 1'b1;
      end
    end else if (special_exp) begin
      if (frac_zero)                   kind_o = K_INF;
      else if (fld_i.frac_left[FRAC_MAX-1]) kind_o = K_QNAN;
      else                             kind_o = K_SNAN;
    end
  end

  // R2: a raised flag always stems from a nonzero fraction under a zero exponent.
  always_comb begin
    if (denorm_flag_o)
      a_r2_flag_from_subnormal: assert (fld_i.exp_zero && !frac_zero);
    if (subnormal_o)
      a_r4_sub_is_finite: assert (kind_o == K_FINITE);
  end

endmodule

// File: rtl/fpu_unpack_lead.sv
module fpu_unpack_lead #(
  parameter int W = 52,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o
);

  // Index of the highest set bit; 0 when the vector is empty.
  function automatic logic [PW-1:0] top_one(logic [W-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  assign pos_o = top_one(vec_i);

  // R4: the reported bit is set and nothing above it is.
  always_comb begin
    if (vec_i != '0)
      a_r4_lead_found: assert ((vec_i >> pos_o) == W'(1));
  end

endmodule

// File: rtl/fpu_operand_unpack.sv
module fpu_operand_unpack
  import fpu_unpack_pkg::*;
(
  input  logic [63:0] operand_i,
  input  logic [1:0]  fmt_i,
  input  logic        flush_i,
  input  logic        flush_half_i,
  input  logic        alt_half_i,
  output logic [2:0]  kind_o,
  output logic        sign_o,
  output logic [11:0] exp_o,
  output logic [63:0] mant_o,
  output logic        in_denorm_o
);

  fmt_e                     fmt;
  fields_t                  fld;
  kind_e                    kind;
  logic                     subnormal;
  logic                     denorm_flag;
  logic [POS_W-1:0]         lead_pos;
  logic signed [EXP_W-1:0]  exp_norm;
  logic signed [EXP_W-1:0]  exp_sub;
  logic [MANT_W-1:0]        mant_norm;
  logic [MANT_W-1:0]        mant_sub;

  assign fmt = fmt_e'(fmt_i);

  fpu_unpack_fields u_fields (
    .op_i  (operand_i),
    .fmt_i (fmt),
    .fld_o (fld)
  );

  fpu_unpack_classify u_classify (
    .fld_i         (fld),
    .fmt_i         (fmt),
    .flush_i       (flush_i),
    .flush_half_i  (flush_half_i),
    .alt_half_i    (alt_half_i),
    .kind_o        (kind),
    .subnormal_o   (subnormal),
    .denorm_flag_o (denorm_flag)
  );

  fpu_unpack_lead #(.W(FRAC_MAX)) u_lead (
    .vec_i (fld.frac_left),
    .pos_o (lead_pos)
  );

  // Normal: hidden one at POINT, fraction (already left-justified) right below it.
  function automatic logic [MANT_W-1:0] build_normal(logic [FRAC_MAX-1:0] fl);
    return {2'b01, fl, {TAIL_W{1'b0}}};
  endfunction

  // Subnormal: move the highest fraction bit up to POINT.
  function automatic logic [MANT_W-1:0] build_sub(logic [FRAC_MAX-1:0] fl,
                                                   logic [POS_W-1:0] p);
    logic [6:0] sh;
    sh = 7'(POINT) - {1'b0, p};
    return {{PAD_W{1'b0}}, fl} << sh;
  endfunction

  // Exponent of a normalized subnormal; the left-justified fraction makes
  // the width term drop out, leaving emin + p - FRAC_MAX.
  function automatic logic signed [EXP_W-1:0] sub_exp(fmt_e f, logic [POS_W-1:0] p);
    return fmt_emin(f) + $signed({{(EXP_W-POS_W){1'b0}}, p}) - 12'(FRAC_MAX);
  endfunction

  assign exp_norm  = $signed({1'b0, fld.exp_raw}) - fmt_bias(fmt);
  assign exp_sub   = sub_exp(fmt, lead_pos);
  assign mant_norm = build_normal(fld.frac_left);
  assign mant_sub  = build_sub(fld.frac_left, lead_pos);

  always_comb begin
    exp_o  = '0;
    mant_o = '0;
    if (kind == K_FINITE) begin
      exp_o  = subnormal ? exp_sub  : exp_norm;
      mant_o = subnormal ? mant_sub : mant_norm;
    end
  end

  assign kind_o      = kind;
  assign sign_o      = fld.sign;
  assign in_denorm_o = denorm_flag;

  always_comb begin
    // R1, R5, R6: non-finite kinds carry no magnitude.
    if (kind != K_FINITE)
      a_r1_nonfinite_clean: assert (exp_o == '0 && mant_o == '0);
    // R4, R8: every finite result has its leading one at POINT.
    if (kind == K_FINITE)
      a_r8_leading_one: assert (mant_o[MANT_W-1:POINT] == 2'b01);
    // R10: the flag needs a flushed zero in a non-half format with flush on.
    if (in_denorm_o)
      a_r10_flag_source: assert (kind_o == 3'd0 && fmt != FMT_HALF && flush_i);
    // R3: half operands never raise the flag.
    if (fmt == FMT_HALF)
      a_r3_half_silent: assert (!in_denorm_o);
    // R6: NaN kinds never come from a zero exponent field.
    if (kind == K_QNAN || kind == K_SNAN)
      a_r6_nan_exp: assert (!fld.exp_zero);
  end

endmodule

// File: tb/test_fpu_operand_unpack.sv
module test_fpu_operand_unpack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  fmt = 2'd0;
  logic        ftz = 1'b0;
  logic        ftzh = 1'b0;
  logic        alt = 1'b0;
  logic [2:0]  kind;
  logic        sign;
  logic [11:0] expo;
  logic [63:0] mant;
  logic        den;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  fpu_operand_unpack i_fpu_operand_unpack (
    .operand_i    (operand),
    .fmt_i        (fmt),
    .flush_i      (ftz),
    .flush_half_i (ftzh),
    .alt_half_i   (alt),
    .kind_o       (kind),
    .sign_o       (sign),
    .exp_o        (expo),
    .mant_o       (mant),
    .in_denorm_o  (den)
  );

  // Reference model written from the requirements.
  task automatic model(input logic [63:0] op, input logic [1:0] f,
                       input logic fz, input logic fzh, input logic al,
                       output logic [2:0] k, output logic s,
                       output logic [11:0] e, output logic [63:0] m,
                       output logic d, output string tag);
    int ew, fw, bias, h;
    logic [63:0] ef, fr;
    case (f)
      2'd0:    begin ew = 5;  fw = 10; bias = 15;   end
      2'd1:    begin ew = 8;  fw = 23; bias = 127;  end
      default: begin ew = 11; fw = 52; bias = 1023; end
    endcase
    ef = (op >> fw) & ((64'd1 << ew) - 64'd1);
    fr = op & ((64'd1 << fw) - 64'd1);
    s  = op[ew + fw];
    k = 3'd1; e = '0; m = '0; d = 1'b0;
    if (ef == 0 && fr == 0) begin
      k = 3'd0; tag = "R1";
    end else if (ef == 0 && f != 2'd0 && fz) begin
      k = 3'd0; d = 1'b1; tag = "R2";
    end else if (ef == 0 && f == 2'd0 && fzh) begin
      k = 3'd0; tag = "R3";
    end else if (ef == 0) begin
      h = 0;
      for (int b = 0; b < 64; b++) if (fr[b]) h = b;
      m = fr << (62 - h);
      e = 12'((1 - bias) - fw + h);
      tag = "R4";
    end else if (ef == (64'd1 << ew) - 64'd1 && !(f == 2'd0 && al)) begin
      if (fr == 0) begin k = 3'd2; tag = "R5"; end
      else begin
        k = fr[fw-1] ? 3'd3 : 3'd4; tag = "R6";
      end
    end else begin
      e = 12'(int'(ef) - bias);
      m = ((64'd1 << fw) | fr) << (62 - fw);
      tag = (f == 2'd0 && ef == 64'd31) ? "R7" : "R8";
    end
  endtask

  // One check per cycle: drive on the falling edge, compare 1 ns later.
  // The denormal flag is compared in every check (R10).
  task automatic check(input logic [63:0] op, input logic [1:0] f,
                       input logic fz, input logic fzh, input logic al,
                       input string force_tag);
    logic [2:0] ek; logic es; logic [11:0] ee; logic [63:0] em; logic ed;
    string tag;
    @(negedge clk);
    operand = op; fmt = f; ftz = fz; ftzh = fzh; alt = al;
    #1;
    model(op, f, fz, fzh, al, ek, es, ee, em, ed, tag);
    if (force_tag != "") tag = force_tag;
    n_checks++;
    if (kind !== ek || sign !== es || expo !== ee || mant !== em || den !== ed) begin
      n_fails++;
      $display("FAIL %s op=%h fmt=%0d ctl=%b%b%b: got k=%0d s=%b e=%h m=%h d=%b, exp k=%0d s=%b e=%h m=%h d=%b",
               tag, op, f, fz, fzh, al, kind, sign, expo, mant, den, ek, es, ee, em, ed);
    end
  endtask

  function automatic logic [63:0] pattern(int j, int fw);
    logic [63:0] msk;
    msk = (64'd1 << fw) - 64'd1;
    case (j)
      0:  return 64'd0;
      1:  return 64'd1;
      2:  return msk;
      3:  return 64'd1 << (fw - 1);
      4:  return 64'd1 << (fw - 2);
      5:  return 64'h5555_5555_5555_5555 & msk;
      6:  return (64'd1 << (fw - 1)) | 64'd1;
      7:  return 64'd1 << (fw / 2);
      8:  return 64'd3;
      9:  return (64'd1 << (fw - 1)) - 64'd1;
      10: return 64'hAAAA_AAAA_AAAA_AAAA & msk;
      default: return 64'd6 << (fw / 3);
    endcase
  endfunction

  function automatic logic [63:0] scramble(int i);
    return 64'(i + 1) * 64'h9E37_79B9_7F4A_7C15;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    // Reset state: all-zero operand reads as a positive zero (R1).
    check(64'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;

    // Full half sweep, upper lanes scrambled, single/double flush toggled
    // (R9, R3 for flush_i, R1/R4/R5/R6/R8).
    for (int i = 0; i < 65536; i++) begin
      logic [63:0] g;
      g = scramble(i);
      check((g << 16) | 64'(i), 2'd0, g[3], 1'b0, 1'b0, "");
    end

    // Half control sweep on the two edge exponents (R3, R7, R5, R6, R4).
    for (int c = 0; c < 4; c++)
      for (int x = 0; x < 2; x++)
        for (int fr = 0; fr < 1024; fr++) begin
          logic [63:0] op;
          op = {48'd0, fr[3], (x == 1) ? 5'd31 : 5'd0, fr[9:0]};
          check(op, 2'd0, fr[1], c[0], c[1], "");
        end

    // Single: every exponent, fraction patterns, both flush settings;
    // half-only controls and upper lanes scrambled (R2, R3, R7, R9).
    for (int ex = 0; ex < 256; ex++)
      for (int j = 0; j < 12; j++)
        for (int z = 0; z < 4; z++) begin
          logic [63:0] g, op;
          g  = scramble(ex * 64 + j * 4 + z);
          op = (g << 32) | (64'(z >> 1) << 31) | (64'(ex) << 23) | pattern(j, 23);
          check(op, 2'd1, z[0], g[5], g[9], "");
        end

    // Double: every exponent (R2, R4, R5, R6, R8).
    for (int ex = 0; ex < 2048; ex++)
      for (int j = 0; j < 8; j++)
        for (int z = 0; z < 2; z++) begin
          logic [63:0] g, op;
          g  = scramble(ex + j);
          op = (64'(ex[0] ^ j[0]) << 63) | (64'(ex) << 52) | pattern(j, 52);
          check(op, 2'd2, z[0], g[2], g[7], "");
        end

    // Format code 3 behaves as double (R9).
    for (int i = 0; i < 256; i++) begin
      logic [63:0] g;
      g = scramble(i * 7);
      if (i < 8) g[62:52] = (i < 4) ? 11'd0 : 11'h7FF;
      check(g, 2'd3, g[0], g[1], g[2], "R9");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule